// File: doc/BRIEF.md
# Five-Step Multi-Cycle Processor Core

This core runs one instruction at a time. Every instruction takes exactly five clock steps: fetch, decode with register read, execute, memory access, and writeback. It supports register-to-register arithmetic and logic, word load, word store, call and return. Values move between steps only through hidden staging registers. RA and RB hold the source operands. RZ holds the execute result. RM holds the store data. RY holds the value to be written back. A save register keeps the program counter during a call.

Instruction fetch and data access share one memory port. The port's address comes from the PC in step 1 and from RZ in step 4. The memory must return read data combinationally, within the same step. The current step number is brought out so a system can see where each instruction is in its sequence.

Top module: `mc5_core`

## Requirements
- R1: In step 1 the core drives the PC on `mem_addr`, latches `mem_rdata` as the instruction, and adds 4 to the PC. In the instruction word, the opcode sits in bits 31:26, field rA in 25:21, field rB in 20:16, field rC in 15:11, and the 16-bit immediate in 15:0.
- R2: `step` counts 0,1,2,3,4 (codes for steps 1 to 5) and then returns to 0, so a fetch happens exactly every five cycles.
- R3: The ALU opcodes are add 0x01, subtract 0x02, and 0x03, or 0x04 and xor 0x05. Each computes rC = rA op rB, carried through RZ and then RY, with the register written in step 5.
- R4: Load word (opcode 0x10) writes rB with the memory word at rA plus the sign-extended immediate.
- R5: Store word (opcode 0x11) writes rB to the address rA plus the sign-extended immediate. `mem_we` is high only in step code 3, and only for a store.
- R6: Register 0 always reads as zero, and any write to it is discarded.
- R7: Call (opcode 0x20) writes the address of the call plus 4 into register 31. It then continues at {PC[31:28], bits 25:0, 2'b00}.
- R8: Return (opcode 0x21) loads the PC from register rA, taken from RA in step 3.
- R9: Any other opcode changes no register and no memory, and still uses all five steps.
- R10: While reset is held, `step` is 0, `mem_we` is 0 and `mem_addr` is 0. The PC resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Byte address: PC in step 1, RZ in step 4 |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Store data (RM) |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| step | output | 3 | Current step code 0 to 4 |

## Verification
The bench runs a program and watches the shared memory port. It compares each fetch address and each store against queued expectations.

- **Sign-extended offsets.** A load followed by a store with a negative offset shows whether the offset is sign extended. A zero-extending core would write far above the intended word.
- **Writes to register 0.** A write to register 0 is followed by a store of that register. A core that lets the write through would store a nonzero value.
- **Undefined opcode.** An undefined opcode whose rC field names a live register is followed by a store of that register. A core that writes back anyway, or shortens the sequence, shows a wrong value or a wrong fetch spacing.
- **Call and return.** A call, a store of the link register, and a return show whether the link value is off by one word. They also show whether the return address is taken from the wrong register, since that would break the fetch address sequence.

// File: rtl/mc5_core.sv
module mc5_core #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int LINK = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [2:0]      step
);
  localparam int RW = $clog2(NREG);
  localparam logic [2:0] S_F = 3'd0, S_D = 3'd1, S_E = 3'd2, S_M = 3'd3, S_W = 3'd4;
  localparam logic [5:0] OP_ADD = 6'h01, OP_SUB = 6'h02, OP_AND = 6'h03, OP_OR = 6'h04,
                         OP_XOR = 6'h05, OP_LDW = 6'h10, OP_STW = 6'h11,
                         OP_CALL = 6'h20, OP_RET = 6'h21;

  logic [XLEN-1:0] pc, ir, ra, rb, rz, rm, ry, pc_save;
  logic [XLEN-1:0] rf [NREG];
  logic [XLEN-1:0] alu, sext, rd_a, rd_b;
  logic [5:0]      op;
  logic [RW-1:0]   fa, fb, fc, dest;
  logic            is_alu, wb_en;

  assign op   = ir[31:26];
  assign fa   = ir[21 +: RW];
  assign fb   = ir[16 +: RW];
  assign fc   = ir[11 +: RW];
  assign sext = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign rd_a = (fa == '0) ? '0 : rf[fa];
  assign rd_b = (fb == '0) ? '0 : rf[fb];
  assign is_alu = (op >= OP_ADD) && (op <= OP_XOR);

  always_comb begin
    case (op)
      OP_ADD:  alu = ra + rb;
      OP_SUB:  alu = ra - rb;
      OP_AND:  alu = ra & rb;
      OP_OR:   alu = ra | rb;
      OP_XOR:  alu = ra ^ rb;
      default: alu = ra + sext;
    endcase
  end

  always_comb begin
    dest  = '0;
    wb_en = 1'b0;
    if (is_alu) begin
      dest = fc; wb_en = 1'b1;
    end else if (op == OP_LDW) begin
      dest = fb; wb_en = 1'b1;
    end else if (op == OP_CALL) begin
      dest = RW'(LINK); wb_en = 1'b1;
    end
  end

  assign mem_addr  = (step == S_M) ? rz : pc;
  assign mem_we    = (step == S_M) && (op == OP_STW);
  assign mem_wdata = rm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= S_F;
      pc      <= '0;
      ir      <= '0;
      ra      <= '0;
      rb      <= '0;
      rz      <= '0;
      rm      <= '0;
      ry      <= '0;
      pc_save <= '0;
    end else begin
      case (step)
        S_F: begin
          ir   <= mem_rdata;
          pc   <= pc + XLEN'(4);
          step <= S_D;
        end
        S_D: begin
          ra   <= rd_a;
          rb   <= rd_b;
          step <= S_E;
        end
        S_E: begin
          rz <= alu;
          rm <= rb;
          if (op == OP_CALL) begin
            pc_save <= pc;
            pc      <= {pc[XLEN-1:28], ir[25:0], 2'b00};
          end else if (op == OP_RET) begin
            pc <= ra;
          end
          step <= S_M;
        end
        S_M: begin
          if (op == OP_LDW)       ry <= mem_rdata;
          else if (op == OP_CALL) ry <= pc_save;
          else                    ry <= rz;
          step <= S_W;
        end
        default: step <= S_F;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && step == S_W && wb_en && dest != '0) rf[dest] <= ry;
  end
endmodule

module mc5_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  step,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] pc
);
  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step == 3'd4 |=> step == 3'd0);
  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step < 3'd4 |=> step == $past(step) + 3'd1);
  // R5
  we_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> step == 3'd3);
  // R1
  pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step == 3'd0 |=> pc == $past(mem_addr) + 32'd4);
  // R1
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd1 || step == 3'd3 || step == 3'd4) |=> $stable(pc));
  // R7
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step == 3'd0 |-> mem_addr[1:0] == 2'b00);
endmodule

bind mc5_core mc5_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .mem_we(mem_we),
  .mem_addr(mem_addr), .pc(pc)
);

// File: tb/mc5_core_test.sv
`timescale 1ns/1ps
module mc5_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [2:0]  step;
  logic [31:0] mem [256];

  int total = 0, bad = 0, cyc = 0, last_fetch = -1;
  bit running = 0;
  logic [31:0] wq_addr[$], wq_data[$], fq_addr[$];
  string       wq_req[$], fq_req[$];

  always #2.5 clk = ~clk;

  mc5_core uut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
                .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .step(step));

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] enc(logic [5:0] op, logic [4:0] a, logic [4:0] b,
                                      logic [4:0] c, logic [15:0] imm);
    enc = {op, a, b, 16'h0};
    if (c != 0) enc[15:11] = c;
    else        enc[15:0]  = imm;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_wr(logic [31:0] a, logic [31:0] d, string req);
    wq_addr.push_back(a); wq_data.push_back(d); wq_req.push_back(req);
  endtask

  task automatic expect_fetch(logic [31:0] a, string req);
    fq_addr.push_back(a); fq_req.push_back(req);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (running && rst_n) begin
      if (step == 3'd0) begin
        if (fq_addr.size() > 0)
          check(fq_req.pop_front(), mem_addr, fq_addr.pop_front());
        if (last_fetch >= 0) check("R2 fetch spacing", 32'(cyc - last_fetch), 32'd5);
        last_fetch = cyc;
      end
      if (mem_we) begin
        check("R5 write step", {29'd0, step}, 32'd3);
        if (wq_addr.size() == 0) check("R5 unexpected write", mem_addr, 32'hxxxxxxxx);
        else begin
          string r = wq_req.pop_front();
          check(r, mem_addr, wq_addr.pop_front());
          check(r, mem_wdata, wq_data.pop_front());
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0]  = enc(6'h10, 0, 1, 0, 16'h0200);
    mem[1]  = enc(6'h10, 0, 2, 0, 16'h0204);
    mem[2]  = enc(6'h10, 0, 10, 0, 16'h0208);
    mem[3]  = enc(6'h01, 1, 2, 3, 0);
    mem[4]  = enc(6'h11, 0, 3, 0, 16'h0300);
    mem[5]  = enc(6'h02, 1, 2, 4, 0);
    mem[6]  = enc(6'h11, 0, 4, 0, 16'h0304);
    mem[7]  = enc(6'h03, 1, 2, 5, 0);
    mem[8]  = enc(6'h04, 1, 2, 6, 0);
    mem[9]  = enc(6'h05, 1, 2, 7, 0);
    mem[10] = enc(6'h11, 0, 5, 0, 16'h0308);
    mem[11] = enc(6'h11, 0, 6, 0, 16'h030C);
    mem[12] = enc(6'h11, 0, 7, 0, 16'h0310);
    mem[13] = enc(6'h01, 1, 1, 0, 0) | 32'h0;
    mem[14] = enc(6'h11, 0, 0, 0, 16'h0314);
    mem[15] = enc(6'h3F, 2, 2, 1, 0);
    mem[16] = enc(6'h11, 0, 1, 0, 16'h0318);
    mem[17] = enc(6'h11, 10, 1, 0, 16'hFFFC);
    mem[18] = {6'h20, 26'h20};
    mem[19] = enc(6'h11, 0, 31, 0, 16'h0328);
    mem[20] = {6'h20, 26'h14};
    mem[32] = enc(6'h11, 0, 31, 0, 16'h0324);
    mem[33] = enc(6'h21, 31, 0, 0, 0);
    mem[128] = 32'd5;
    mem[129] = 32'hFFFF_FFFD;
    mem[130] = 32'h0000_0320;

    for (int i = 0; i < 19; i++) expect_fetch(32'(i * 4), (i == 16) ? "R9 fetch after undefined" : "R1 fetch");
    expect_fetch(32'h80, "R7 call target");
    expect_fetch(32'h84, "R1 fetch");
    expect_fetch(32'h4C, "R8 return target");
    expect_fetch(32'h50, "R1 fetch");
    expect_fetch(32'h50, "R7 self call");

    expect_wr(32'h300, 32'd2,          "R3 add / R4 load");
    expect_wr(32'h304, 32'd8,          "R3 sub");
    expect_wr(32'h308, 32'd5,          "R3 and");
    expect_wr(32'h30C, 32'hFFFF_FFFD,  "R3 or");
    expect_wr(32'h310, 32'hFFFF_FFF8,  "R3 xor");
    expect_wr(32'h314, 32'd0,          "R6 r0 write ignored");
    expect_wr(32'h318, 32'd5,          "R9 undefined no-op");
    expect_wr(32'h31C, 32'd5,          "R4 R5 negative offset");
    expect_wr(32'h324, 32'h4C,         "R7 link value");
    expect_wr(32'h328, 32'h4C,         "R8 link after return");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset step", {29'd0, step}, 32'd0);
    check("R10 reset we", {31'd0, mem_we}, 32'd0);
    check("R10 reset addr", mem_addr, 32'd0);
    running = 1;
    rst_n = 1'b1;

    fork
      begin
        wait (wq_addr.size() == 0 && fq_addr.size() == 0);
        repeat (5) @(posedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule